// File: doc/BRIEF.md
# Warp Global Memory Access Coalescer

This block sits between the address stage of a wide SIMT load/store pipeline and the device-memory request path. A warp of 32 lanes hands over one memory instruction in a single request handshake. The request carries every lane's byte address, an active-lane mask and the word size of the access. The block then turns that instruction into the smallest set of naturally aligned device-memory transactions. Each transaction is 32, 64 or 128 bytes long and carries the mask of the lanes it serves.

Lanes are grouped by the 128-byte aligned window their address falls in. Each window becomes exactly one transaction. That transaction is shrunk to an aligned 32-byte or 64-byte segment whenever the bytes the lanes touch fit inside one. Transactions leave one per cycle on a valid/ready handshake. They are ordered by the lowest lane each one serves. A lane whose address is not a multiple of its word size is reported and left out. A one-cycle done pulse marks the end of the instruction.

Top module: `warp_coalescer`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when no transaction of the previous request is still pending.
- R2: Every transaction base address is a multiple of its segment length. `txn_len` encodes the length as 0 = 32 bytes, 1 = 64 bytes and 2 = 128 bytes.
- R3: All served lanes whose addresses share one 128-byte aligned window (address bits above bit 6) are carried by a single transaction.
- R4: A window's touched bytes run from the lowest lane offset to the highest lane offset plus word size minus one. If that span lies in one aligned 32-byte segment, the length is 32 bytes. Otherwise, if it lies in one aligned 64-byte segment, the length is 64 bytes. Otherwise it is 128 bytes. The base is the start of the chosen segment.
- R5: Transactions leave in increasing order of the lowest-numbered lane each one serves.
- R6: Across one request, the lane masks of the transactions are disjoint, and together they equal the set of active, aligned lanes.
- R7: Lanes whose `req_mask` bit is 0 are ignored. A request with no served lane emits no transaction and pulses `done` on the edge that follows the capture.
- R8: `req_size` code k selects a word of 2^k bytes, with codes 4 to 7 meaning 16 bytes. An active lane whose address is not a multiple of its word size is set in `err_lanes`, and it appears in no transaction. `err_lanes` is updated when a request is taken and is held until the next request is taken.
- R9: `done` is high for exactly one cycle, on the edge after the last transaction is accepted, and no transaction is offered while it is high.
- R10: While `txn_valid` is high and `txn_ready` is low, the offered base, length and lane mask stay unchanged.
- R11: After reset, `txn_valid`, `done` and `err_lanes` are 0, and `req_ready` is 1.
- R12: When 32 active lanes read consecutive 4-byte words starting at a 128-byte aligned base, exactly one 128-byte transaction serving all lanes is emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Instruction offered |
| req_ready | output | 1 | Block idle, able to take an instruction |
| req_addr | input | LANES*AW | Per-lane byte addresses, lane i at bits [i*AW +: AW] |
| req_mask | input | LANES | Active-lane mask |
| req_size | input | 3 | Word size code, 2^code bytes, capped at 16 |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Downstream accepts the transaction |
| txn_base | output | AW | Segment base address |
| txn_len | output | 2 | Segment length code (0:32, 1:64, 2:128 bytes) |
| txn_lanes | output | LANES | Lanes served by this transaction |
| done | output | 1 | One-cycle end-of-instruction pulse |
| err_lanes | output | LANES | Misaligned active lanes of the last request |

## Verification
Unit-stride patterns at several word sizes and strides check how segment counts grow with word size and spacing. Broadcast patterns, where every lane reads one address, check the 32-byte shrink. Lanes scattered over a few windows check the grouping and the lowest-lane ordering, and fully random addresses check the case of one transaction per lane. Misaligned lanes, sparse masks and the empty mask check exclusion and the immediate done pulse. Directed spans that just fit or just miss a 32-byte or 64-byte segment separate the three length choices. A random ready signal tests that stalled transactions are held.

// File: rtl/coal_pkg.sv
// Shared types and helpers for the warp coalescer.
// Assumes word size codes follow 2^code bytes with a 16-byte ceiling.
package coal_pkg;

    typedef enum logic [1:0] {
        SEG_32  = 2'd0,
        SEG_64  = 2'd1,
        SEG_128 = 2'd2
    } seg_len_e;

    localparam int WIN_BITS = 7;   // 128-byte window offset width

    // Bytes per lane word for a size code.
    function automatic logic [4:0] word_bytes(input logic [2:0] code);
        if (code >= 3'd4) return 5'd16;
        return 5'(1) << code;
    endfunction

endpackage

// File: rtl/coal_lane_check.sv
// Per-lane alignment screen: splits the active mask into served lanes
// and misaligned lanes. Purely combinational; assumes AW >= 5.
module coal_lane_check #(
    parameter int LANES = 32,
    parameter int AW    = 32
) (
    input  logic [LANES*AW-1:0] addr,
    input  logic [LANES-1:0]    mask,
    input  logic [2:0]          size,
    output logic [LANES-1:0]    ok_mask,
    output logic [LANES-1:0]    bad_mask
);
    import coal_pkg::*;

    logic [4:0] low_mask;
    assign low_mask = word_bytes(size) - 5'd1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic misal;
        // Lane misaligned when any address bit below the word size is set.
        assign misal       = (addr[g*AW +: 5] & low_mask) != 5'd0;
        assign bad_mask[g] = mask[g] & misal;
        assign ok_mask[g]  = mask[g] & ~misal;
    end

endmodule

// File: rtl/coal_window_select.sv
// Picks the lowest pending lane as leader, gathers all pending lanes in
// the leader's 128-byte window and reports the touched byte span there.
// Assumes every pending lane is aligned to its word size.
module coal_window_select #(
    parameter int LANES = 32,
    parameter int AW    = 32,
    localparam int LW   = $clog2(LANES)
) (
    input  logic [LANES*AW-1:0] addr,
    input  logic [LANES-1:0]    pending,
    input  logic [2:0]          size,
    output logic [AW-8:0]       win,
    output logic [LANES-1:0]    match,
    output logic [6:0]          lo,
    output logic [6:0]          hi
);
    import coal_pkg::*;

    logic [LW-1:0] leader;
    logic [6:0]    span;

    assign span = 7'(word_bytes(size)) - 7'd1;

    // Priority pick of the lowest-numbered pending lane.
    always_comb begin
        leader = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) leader = LW'(i);
        end
    end

    assign win = addr[leader*AW + WIN_BITS +: AW - WIN_BITS];

    // Window membership and lowest/highest touched byte offset.
    always_comb begin
        lo    = 7'h7f;
        hi    = 7'h00;
        match = '0;
        for (int i = 0; i < LANES; i++) begin
            if (pending[i] && addr[i*AW + WIN_BITS +: AW - WIN_BITS] == win) begin
                match[i] = 1'b1;
                if (addr[i*AW +: 7] < lo) lo = addr[i*AW +: 7];
                if (addr[i*AW +: 7] + span > hi) hi = addr[i*AW +: 7] + span;
            end
        end
    end

endmodule

// File: rtl/coal_segment_fit.sv
// Chooses the smallest aligned segment (32, 64 or 128 bytes) inside a
// window that covers the byte span [lo, hi]. Assumes lo <= hi.
module coal_segment_fit #(
    parameter int AW = 32
) (
    input  logic [AW-8:0] win,
    input  logic [6:0]    lo,
    input  logic [6:0]    hi,
    output logic [AW-1:0] base,
    output logic [1:0]    len
);
    import coal_pkg::*;

    // Shrink to 32 bytes, then 64, else the full window.
    always_comb begin
        if (lo[6:5] == hi[6:5]) begin
            len  = SEG_32;
            base = {win, lo[6:5], 5'd0};
        end else if (lo[6] == hi[6]) begin
            len  = SEG_64;
            base = {win, lo[6], 6'd0};
        end else begin
            len  = SEG_128;
            base = {win, 7'd0};
        end
    end

endmodule

// File: rtl/warp_coalescer.sv
// Warp global memory access coalescer. Captures one warp instruction,
// then emits one aligned transaction per 128-byte window per cycle over
// valid/ready, lowest lane first, and pulses done at the end.
// Assumes AW > 7 and that downstream keeps txn_ready independent of txn_valid.
module warp_coalescer #(
    parameter int LANES = 32,
    parameter int AW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [LANES*AW-1:0] req_addr,
    input  logic [LANES-1:0]    req_mask,
    input  logic [2:0]          req_size,
    output logic                txn_valid,
    input  logic                txn_ready,
    output logic [AW-1:0]       txn_base,
    output logic [1:0]          txn_len,
    output logic [LANES-1:0]    txn_lanes,
    output logic                done,
    output logic [LANES-1:0]    err_lanes
);

    logic [LANES*AW-1:0] addr_q;
    logic [2:0]          size_q;
    logic [LANES-1:0]    pend_q;
    logic [LANES-1:0]    ok_mask, bad_mask, match, remain;
    logic [AW-8:0]       win;
    logic [6:0]          lo, hi;
    logic                capture, accept;

    coal_lane_check #(.LANES(LANES), .AW(AW)) u_check (
        .addr(req_addr), .mask(req_mask), .size(req_size),
        .ok_mask(ok_mask), .bad_mask(bad_mask)
    );

    coal_window_select #(.LANES(LANES), .AW(AW)) u_select (
        .addr(addr_q), .pending(pend_q), .size(size_q),
        .win(win), .match(match), .lo(lo), .hi(hi)
    );

    coal_segment_fit #(.AW(AW)) u_fit (
        .win(win), .lo(lo), .hi(hi), .base(txn_base), .len(txn_len)
    );

    assign req_ready = (pend_q == '0);
    assign capture   = req_valid && req_ready;
    assign txn_valid = (pend_q != '0);
    assign txn_lanes = match;
    assign accept    = txn_valid && txn_ready;
    assign remain    = pend_q & ~match;

    // Request capture and retirement of served lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            size_q    <= '0;
            pend_q    <= '0;
            err_lanes <= '0;
            done      <= 1'b0;
        end else begin
            done <= (capture && ok_mask == '0) || (accept && remain == '0);
            if (capture) begin
                addr_q    <= req_addr;
                size_q    <= req_size;
                pend_q    <= ok_mask;
                err_lanes <= bad_mask;
            end else if (accept) begin
                pend_q <= remain;
            end
        end
    end

    // R1
    rise_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txn_valid) |-> $past(req_valid && req_ready));

    // R2
    base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_len == 2'd0 && txn_base[4:0] == 5'd0) ||
                       (txn_len == 2'd1 && txn_base[5:0] == 6'd0) ||
                       (txn_len == 2'd2 && txn_base[6:0] == 7'd0)));

    // R6
    lanes_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready) |=> (!txn_valid || (txn_lanes & $past(txn_lanes)) == '0));

    // R8
    err_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_lanes & err_lanes) == '0);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !txn_valid);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=>
            ($stable(txn_base) && $stable(txn_len) && $stable(txn_lanes)));

endmodule

// File: tb/warp_coalescer_bench.sv
module warp_coalescer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 32;
    localparam int AW    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [LANES*AW-1:0] req_addr = '0;
    logic [LANES-1:0] req_mask = '0;
    logic [2:0] req_size = '0;
    logic txn_valid;
    logic txn_ready = 1'b0;
    logic [AW-1:0] txn_base;
    logic [1:0] txn_len;
    logic [LANES-1:0] txn_lanes;
    logic done;
    logic [LANES-1:0] err_lanes;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [31:0] a [LANES];
    logic [31:0] m;
    logic [2:0]  sz;
    logic [31:0] exp_base [LANES];
    logic [1:0]  exp_len [LANES];
    logic [31:0] exp_lanes [LANES];
    logic [31:0] exp_bad;
    int exp_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    warp_coalescer #(.LANES(LANES), .AW(AW)) u_warp_coalescer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask), .req_size(req_size),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_base(txn_base),
        .txn_len(txn_len), .txn_lanes(txn_lanes), .done(done), .err_lanes(err_lanes)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int bytes_of(input logic [2:0] c);
        return (c >= 3'd4) ? 16 : (1 << c);
    endfunction

    // Expected transaction list built from R3..R8.
    task automatic build_expected();
        logic [31:0] pend;
        int bw;
        bw = bytes_of(sz);
        exp_bad = '0;
        for (int i = 0; i < LANES; i++)
            if (m[i] && (a[i] % bw) != 0) exp_bad[i] = 1'b1;
        pend = m & ~exp_bad;
        exp_n = 0;
        while (pend != 0) begin
            int ld, lo, hi;
            logic [24:0] w;
            logic [31:0] ln;
            ld = 0;
            for (int i = LANES - 1; i >= 0; i--) if (pend[i]) ld = i;
            w = a[ld][31:7];
            lo = 127; hi = 0; ln = '0;
            for (int i = 0; i < LANES; i++) begin
                if (pend[i] && a[i][31:7] == w) begin
                    ln[i] = 1'b1;
                    if (int'(a[i][6:0]) < lo) lo = int'(a[i][6:0]);
                    if (int'(a[i][6:0]) + bw - 1 > hi) hi = int'(a[i][6:0]) + bw - 1;
                end
            end
            if (lo / 32 == hi / 32) begin
                exp_len[exp_n] = 2'd0; exp_base[exp_n] = {w, 7'd0} + 32'((lo / 32) * 32);
            end else if (lo / 64 == hi / 64) begin
                exp_len[exp_n] = 2'd1; exp_base[exp_n] = {w, 7'd0} + 32'((lo / 64) * 64);
            end else begin
                exp_len[exp_n] = 2'd2; exp_base[exp_n] = {w, 7'd0};
            end
            exp_lanes[exp_n] = ln;
            exp_n++;
            pend &= ~ln;
        end
    endtask

    task automatic run_req(input string tag);
        int got, guard;
        build_expected();
        @(negedge clk);
        check(req_ready == 1'b1, "R1", {tag, " ready when idle"}, 64'(req_ready), 64'd1);
        for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = a[i];
        req_mask = m; req_size = sz; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = '0; req_mask = '0;
        #1;
        check(err_lanes == exp_bad, "R8", {tag, " err_lanes"}, 64'(err_lanes), 64'(exp_bad));
        got = 0; guard = 0;
        while (got < exp_n && guard < 500) begin
            txn_ready = ($urandom % 4) != 0;
            #1;
            if (txn_valid && txn_ready) begin
                check(txn_base == exp_base[got], "R4", {tag, " base"}, 64'(txn_base), 64'(exp_base[got]));
                check(txn_len == exp_len[got], "R4", {tag, " length"}, 64'(txn_len), 64'(exp_len[got]));
                check(txn_lanes == exp_lanes[got], "R5", {tag, " lane order/mask"}, 64'(txn_lanes), 64'(exp_lanes[got]));
                got++;
            end else if (!txn_valid) begin
                check(1'b0, "R6", {tag, " transaction count"}, 64'(got), 64'(exp_n));
                guard = 1000;
            end
            if (guard < 1000) begin
                @(negedge clk);
                guard++;
            end
        end
        txn_ready = 1'b0;
        #1;
        if (guard < 1000) begin
            check(txn_valid == 1'b0, "R6", {tag, " no extra transaction"}, 64'(txn_valid), 64'd0);
            check(done == 1'b1, "R9", {tag, " done pulse"}, 64'(done), 64'd1);
            @(negedge clk);
            #1;
            check(done == 1'b0, "R9", {tag, " done single cycle"}, 64'(done), 64'd0);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < LANES; i++) a[i] = '0;
        m = '0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1;
        check(txn_valid == 1'b0, "R11", "reset txn_valid", 64'(txn_valid), 64'd0);
        check(done == 1'b0, "R11", "reset done", 64'(done), 64'd0);
        check(req_ready == 1'b1, "R11", "reset req_ready", 64'(req_ready), 64'd1);
        check(err_lanes == '0, "R11", "reset err_lanes", 64'(err_lanes), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R12: unit-stride 4-byte words from aligned base
        clear_all();
        for (int i = 0; i < LANES; i++) a[i] = 32'h0000_4000 + 32'(i * 4);
        m = '1; sz = 3'd2;
        run_req("R12 unit stride");
        check(exp_n == 1 && exp_len[0] == 2'd2, "R12", "model single 128B", 64'(exp_n), 64'd1);

        // R7: empty mask
        clear_all(); sz = 3'd2;
        for (int i = 0; i < LANES; i++) a[i] = 32'(i * 256);
        run_req("R7 empty mask");

        // R7: inactive lanes ignored in a different window
        clear_all(); sz = 3'd2; m = 32'h0000_00ff;
        for (int i = 0; i < LANES; i++) a[i] = (i < 8) ? 32'h100 + 32'(i * 4) : 32'h9000;
        run_req("R7 inactive ignored");

        // R8: all lanes misaligned
        clear_all(); sz = 3'd3; m = '1;
        for (int i = 0; i < LANES; i++) a[i] = 32'h200 + 32'(i * 8) + 32'd4;
        run_req("R8 all misaligned");

        // R4: span fits one 32B segment
        clear_all(); sz = 3'd2; m = 32'h0000_00ff;
        for (int i = 0; i < 8; i++) a[i] = 32'h1020 + 32'(i * 4);
        run_req("R4 fit 32");

        // R4: span fits one 64B segment
        clear_all(); sz = 3'd1; m = 32'h3;
        a[0] = 32'h2046; a[1] = 32'h2078;
        run_req("R4 fit 64");

        // R4: span crosses 64B boundary within window
        clear_all(); sz = 3'd2; m = 32'h3;
        a[0] = 32'h303c; a[1] = 32'h3044;
        run_req("R4 need 128");

        // R5/R3: lane 0 in higher window emitted first
        clear_all(); sz = 3'd2; m = 32'hf;
        a[0] = 32'h5280; a[1] = 32'h5100; a[2] = 32'h5284; a[3] = 32'h5104;
        run_req("R5 order");

        // Random mixes
        for (int t = 0; t < 300; t++) begin
            int kind, bw;
            clear_all();
            sz = 3'($urandom % 8);
            bw = bytes_of(sz);
            kind = $urandom % 5;
            m = ($urandom % 3 == 0) ? 32'hffff_ffff : $urandom;
            for (int i = 0; i < LANES; i++) begin
                case (kind)
                    0: a[i] = 32'h0001_0000 + 32'(i * bw * (1 + t % 3));
                    1: a[i] = (32'h0002_0000 + ($urandom % 512)) & ~32'(bw - 1);
                    2: a[i] = 32'h0003_0040 & ~32'(bw - 1);
                    3: a[i] = $urandom & ~32'(bw - 1);
                    default: begin
                        a[i] = (32'h0004_0000 + ($urandom % 384)) & ~32'(bw - 1);
                        if (bw > 1 && ($urandom % 6) == 0) a[i] = a[i] + 32'd1;
                    end
                endcase
            end
            run_req("R3 R6 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule